// File: doc/BRIEF.md
# Windowed Reflection Peak and Threshold Monitor

This block sits behind the sample converter of a cable-reflection test. When the pulse generator launches a test pulse it raises a one-cycle launch strobe. From the clock after that strobe, an internal time index counts one step per 8 ns clock, and the block watches one of two signed sample streams: the stream from the transmit pair or the stream from the receive pair. Only samples whose time index lies inside a programmable inclusive window are examined. This lets software hide the launched pulse itself, or look for a second reflection further out.

Inside the window the block finds the most positive sample, or the most negative one in min polarity, and the time index at which that value first appears. It also records the first sample that reaches a programmable threshold, with its time index. When the window closes, a done flag rises and the results stay frozen until the next launch. Software turns the time indices into distances and averages several runs. Polarity, pair, window bounds and threshold are taken once, at launch.

Top module: `refl_window_monitor`

## Requirements
- R1: After synchronous reset, `done`, `peak_found`, `thr_found`, `peak_val`, `peak_time`, `thr_val` and `thr_time` are all zero.
- R2: A launch strobe clears `done`, `peak_found` and `thr_found` at the next clock edge. The sample presented during the first cycle after the launch edge has time index 0, and each following cycle adds one.
- R3: A sample qualifies only when its time index t satisfies `win_first <= t <= win_last`. Both bounds are inclusive and unsigned. A sample outside the window changes no result.
- R4: With `min_mode` = 0, `peak_val` is the largest qualifying sample and `peak_time` is the index where that value first appears. A later equal sample does not move `peak_time`. `peak_found` is 1 if any sample qualified.
- R5: With `min_mode` = 1, `peak_val` is the smallest qualifying sample, and `peak_time` is the index where that value first appears.
- R6: `thr_found`, `thr_val` and `thr_time` report the first qualifying sample with `sample >= thresh` (`min_mode` = 0) or `sample <= thresh` (`min_mode` = 1). If no sample meets the test, `thr_found` stays 0.
- R7: `done` rises one cycle after the sample at index `win_last` is presented, and not earlier. It stays high, with all results unchanged, until the next launch. The run also ends at index 255.
- R8: When `win_first > win_last`, no sample qualifies. `done` still rises, and `peak_found` and `thr_found` stay 0.
- R9: `pair_sel` = 0 watches `adc_tx` (the default after reset), and `pair_sel` = 1 watches `adc_rx`.
- R10: `min_mode`, `pair_sel`, `win_first`, `win_last` and `thresh` are captured at the launch edge. Changes to them during a run have no effect on that run.
- R11: A launch during a run restarts the run. Results then reflect only samples after the new launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | One-cycle strobe at pulse launch |
| pair_sel | input | 1 | Stream select: 0 transmit pair, 1 receive pair |
| min_mode | input | 1 | Polarity: 0 maximum, 1 minimum |
| win_first | input | TIME_W | First time index examined |
| win_last | input | TIME_W | Last time index examined |
| thresh | input | SAMPLE_W | Signed threshold |
| adc_tx | input | SAMPLE_W | Signed samples from the transmit pair |
| adc_rx | input | SAMPLE_W | Signed samples from the receive pair |
| done | output | 1 | Run finished, results valid |
| peak_found | output | 1 | At least one sample qualified |
| peak_val | output | SAMPLE_W | Extreme qualifying sample |
| peak_time | output | TIME_W | First index of the extreme value |
| thr_found | output | 1 | Threshold was reached |
| thr_val | output | SAMPLE_W | Sample that first reached the threshold |
| thr_time | output | TIME_W | Index of that sample |

## Verification
If the time index is off by one, every reported time shifts by one and `done` rises a cycle early or late. Each run exposes this against the model as soon as the window closes. A window compare that is wrong at a bound shows up as a wrong peak or threshold index at the end of a run whose extreme sits on the edge sample. Broken tie handling or a bad polarity select gives a wrong `peak_time` or `peak_val` in the same run. Configuration that is not latched, or a restart that leaks old state, corrupts the results of the run in which the bench scrambles the inputs or relaunches.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  typedef enum logic {
    POL_MAX = 1'b0,
    POL_MIN = 1'b1
  } polarity_e;
endpackage

// File: rtl/rwm_timer.sv
module rwm_timer #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [TIME_W-1:0] first_i,
  input  logic [TIME_W-1:0] last_i,
  output logic [TIME_W-1:0] tick_o,
  output logic              qual_o,
  output logic              done_o
);
  localparam logic [TIME_W-1:0] T_MAX = '1;

  logic active;
  logic at_end;

  assign at_end = (tick_o == last_i) || (tick_o == T_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= '0;
      active <= 1'b0;
      done_o <= 1'b0;
    end else if (launch) begin
      tick_o <= '0;
      active <= 1'b1;
      done_o <= 1'b0;
    end else if (active) begin
      if (at_end) begin
        active <= 1'b0;
        done_o <= 1'b1;
      end else begin
        tick_o <= tick_o + 1'b1;
      end
    end
  end

  assign qual_o = active && (tick_o >= first_i) && (tick_o <= last_i);

  assert_launch_restart_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (active && tick_o == '0 && !done_o));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !active);

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !launch) |=> done_o);
endmodule

// File: rtl/rwm_extreme.sv
module rwm_extreme #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned TIME_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       qual,
  input  rwm_pkg::polarity_e         pol,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [TIME_W-1:0]   tick,
  output logic                       found,
  output logic signed [SAMPLE_W-1:0] val,
  output logic        [TIME_W-1:0]   at
);
  logic better;

  always_comb begin
    if (pol == rwm_pkg::POL_MIN) better = (sample < val);
    else                         better = (sample > val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      found <= 1'b0;
      val   <= '0;
      at    <= '0;
    end else if (clear) begin
      found <= 1'b0;
      val   <= '0;
      at    <= '0;
    end else if (qual && (!found || better)) begin
      found <= 1'b1;
      val   <= sample;
      at    <= tick;
    end
  end

  assert_found_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (found && !clear) |=> found);

  assert_max_rises_R4: assert property (@(posedge clk) disable iff (rst)
    (found && !clear && pol == rwm_pkg::POL_MAX) |=> (val >= $past(val)));

  assert_min_falls_R5: assert property (@(posedge clk) disable iff (rst)
    (found && !clear && pol == rwm_pkg::POL_MIN) |=> (val <= $past(val)));
endmodule

// File: rtl/rwm_threshold.sv
module rwm_threshold #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned TIME_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       qual,
  input  rwm_pkg::polarity_e         pol,
  input  logic signed [SAMPLE_W-1:0] limit,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [TIME_W-1:0]   tick,
  output logic                       found,
  output logic signed [SAMPLE_W-1:0] val,
  output logic        [TIME_W-1:0]   at
);
  logic crossed;

  always_comb begin
    if (pol == rwm_pkg::POL_MIN) crossed = (sample <= limit);
    else                         crossed = (sample >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      found <= 1'b0;
      val   <= '0;
      at    <= '0;
    end else if (clear) begin
      found <= 1'b0;
      val   <= '0;
      at    <= '0;
    end else if (qual && !found && crossed) begin
      found <= 1'b1;
      val   <= sample;
      at    <= tick;
    end
  end

  assert_first_cross_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (found && !clear) |=> (found && $stable(val) && $stable(at)));
endmodule

// File: rtl/refl_window_monitor.sv
module refl_window_monitor #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned TIME_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       launch,
  input  logic                       pair_sel,
  input  logic                       min_mode,
  input  logic        [TIME_W-1:0]   win_first,
  input  logic        [TIME_W-1:0]   win_last,
  input  logic signed [SAMPLE_W-1:0] thresh,
  input  logic signed [SAMPLE_W-1:0] adc_tx,
  input  logic signed [SAMPLE_W-1:0] adc_rx,
  output logic                       done,
  output logic                       peak_found,
  output logic signed [SAMPLE_W-1:0] peak_val,
  output logic        [TIME_W-1:0]   peak_time,
  output logic                       thr_found,
  output logic signed [SAMPLE_W-1:0] thr_val,
  output logic        [TIME_W-1:0]   thr_time
);
  import rwm_pkg::*;

  // Run configuration, captured once per launch.
  logic                       cfg_pair;
  polarity_e                  cfg_pol;
  logic        [TIME_W-1:0]   cfg_first;
  logic        [TIME_W-1:0]   cfg_last;
  logic signed [SAMPLE_W-1:0] cfg_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pair  <= 1'b0;
      cfg_pol   <= POL_MAX;
      cfg_first <= '0;
      cfg_last  <= '1;
      cfg_thr   <= '0;
    end else if (launch) begin
      cfg_pair  <= pair_sel;
      cfg_pol   <= polarity_e'(min_mode);
      cfg_first <= win_first;
      cfg_last  <= win_last;
      cfg_thr   <= thresh;
    end
  end

  logic signed [SAMPLE_W-1:0] sample;
  logic        [TIME_W-1:0]   tick;
  logic                       qual;

  assign sample = cfg_pair ? adc_rx : adc_tx;

  rwm_timer #(.TIME_W(TIME_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .first_i (cfg_first),
    .last_i  (cfg_last),
    .tick_o  (tick),
    .qual_o  (qual),
    .done_o  (done)
  );

  rwm_extreme #(.SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W)) u_peak (
    .clk    (clk),
    .rst    (rst),
    .clear  (launch),
    .qual   (qual),
    .pol    (cfg_pol),
    .sample (sample),
    .tick   (tick),
    .found  (peak_found),
    .val    (peak_val),
    .at     (peak_time)
  );

  rwm_threshold #(.SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .clear  (launch),
    .qual   (qual),
    .pol    (cfg_pol),
    .limit  (cfg_thr),
    .sample (sample),
    .tick   (tick),
    .found  (thr_found),
    .val    (thr_val),
    .at     (thr_time)
  );

  assert_outside_window_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!launch && !qual) |=> ($stable(peak_val) && $stable(peak_time) &&
                            $stable(thr_val) && $stable(thr_time)));

  assert_empty_window_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_first > cfg_last && !launch) |=> ($stable(peak_found) && $stable(thr_found)));

  assert_results_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !launch) |=> ($stable(peak_val) && $stable(peak_time) && $stable(thr_time)));
endmodule

// File: tb/refl_window_monitor_test.sv
module refl_window_monitor_test;
  localparam int SW = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst, launch, pair_sel, min_mode;
  logic        [TW-1:0] win_first, win_last;
  logic signed [SW-1:0] thresh, adc_tx, adc_rx;
  logic                 done, peak_found, thr_found;
  logic signed [SW-1:0] peak_val, thr_val;
  logic        [TW-1:0] peak_time, thr_time;

  refl_window_monitor #(.SAMPLE_W(SW), .TIME_W(TW)) uut (
    .clk(clk), .rst(rst), .launch(launch), .pair_sel(pair_sel), .min_mode(min_mode),
    .win_first(win_first), .win_last(win_last), .thresh(thresh),
    .adc_tx(adc_tx), .adc_rx(adc_rx), .done(done), .peak_found(peak_found),
    .peak_val(peak_val), .peak_time(peak_time), .thr_found(thr_found),
    .thr_val(thr_val), .thr_time(thr_time)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic signed [SW-1:0] sa [256];
  logic signed [SW-1:0] sb [256];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    for (int k = 0; k < 256; k++) begin
      case (kind)
        0:       begin sa[k] = SW'($urandom); sb[k] = SW'($urandom); end
        1:       begin sa[k] = SW'(int'($urandom_range(6)) - 3);
                       sb[k] = SW'(int'($urandom_range(6)) - 3); end
        default: begin sa[k] = 10'sd5; sb[k] = -10'sd7; end
      endcase
    end
  endtask

  task automatic model(input bit mm, input bit ps, input int f, input int l, input int th,
                       output bit pf, output int pv, output int pt,
                       output bit tf, output int tv, output int tt);
    pf = 0; pv = 0; pt = 0; tf = 0; tv = 0; tt = 0;
    for (int k = 0; k <= l; k++) begin
      int s;
      s = ps ? int'(sb[k]) : int'(sa[k]);
      if (k >= f) begin
        if (!pf || (mm ? s < pv : s > pv)) begin pf = 1; pv = s; pt = k; end
        if (!tf && (mm ? s <= th : s >= th)) begin tf = 1; tv = s; tt = k; end
      end
    end
  endtask

  task automatic run(input bit mm, input bit ps, input int f, input int l, input int th,
                     input string ctx);
    bit early, pf, tf;
    int pv, pt, tv, tt;
    string pk;
    pk = mm ? {ctx, "/R5"} : {ctx, "/R4"};
    @(negedge clk);
    min_mode = mm; pair_sel = ps; win_first = TW'(f); win_last = TW'(l);
    thresh = SW'(th); launch = 1'b1;
    adc_tx = SW'($urandom); adc_rx = SW'($urandom);
    @(negedge clk);
    launch = 1'b0;
    // scramble configuration mid-run (R10)
    min_mode = 1'($urandom); pair_sel = 1'($urandom);
    win_first = TW'($urandom); win_last = TW'($urandom); thresh = SW'($urandom);
    early = 0;
    for (int k = 0; k <= l; k++) begin
      if (k > 0) @(negedge clk);
      if (done) early = 1;
      adc_tx = sa[k]; adc_rx = sb[k];
    end
    chk(!early, {ctx, "/R2/R7"}, "done before window end", early, 0);
    @(negedge clk);
    adc_tx = SW'($urandom); adc_rx = SW'($urandom);
    model(mm, ps, f, l, th, pf, pv, pt, tf, tv, tt);
    chk(done == 1'b1, {ctx, "/R7"}, "done", done, 1);
    chk(peak_found == pf, pk, "peak_found", peak_found, pf);
    chk(int'(peak_val) == pv, pk, "peak_val", peak_val, pv);
    chk(int'(peak_time) == pt, pk, "peak_time", peak_time, pt);
    chk(thr_found == tf, {ctx, "/R6"}, "thr_found", thr_found, tf);
    chk(int'(thr_val) == tv, {ctx, "/R6"}, "thr_val", thr_val, tv);
    chk(int'(thr_time) == tt, {ctx, "/R6"}, "thr_time", thr_time, tt);
    repeat (3) begin
      @(negedge clk);
      adc_tx = SW'($urandom); adc_rx = SW'($urandom);
    end
    chk(done == 1'b1 && int'(peak_val) == pv && int'(thr_time) == tt, {ctx, "/R7"},
        "results held after done", peak_val, pv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, got %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    rst = 1'b1; launch = 1'b0; pair_sel = 1'b0; min_mode = 1'b0;
    win_first = '0; win_last = '1; thresh = '0; adc_tx = '0; adc_rx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !peak_found && !thr_found && peak_val == 0 && peak_time == 0 &&
        thr_val == 0 && thr_time == 0, "R1", "reset state",
        {done, peak_found, thr_found}, 0);

    // directed corner cases
    fill(0); run(0, 0, 0, 255, 200, "R3 full window");
    fill(0); run(1, 0, 0, 255, -200, "R5 min full window");
    fill(2); run(0, 0, 10, 40, 5, "R4 equal values tie");
    fill(2); run(1, 1, 3, 9, -7, "R9 rx pair tie");
    fill(0); run(0, 0, 50, 20, 0, "R8 inverted window");
    fill(0); run(0, 0, 17, 17, -512, "R3 single index window");
    fill(0); run(0, 1, 0, 100, 511, "R6 threshold never met");
    fill(1); run(1, 1, 5, 60, 511, "R9 rx min");
    fill(0); run(0, 0, 0, 0, 0, "R3 index zero only");

    // restart during a run
    fill(0);
    @(negedge clk);
    min_mode = 1'b1; win_first = 8'd0; win_last = 8'd200; launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    for (int k = 0; k < 30; k++) begin
      adc_tx = 10'sd511; adc_rx = -10'sd512;
      @(negedge clk);
    end
    run(0, 0, 0, 60, 100, "R11 restart");

    // constrained random runs
    for (int r = 0; r < 30; r++) begin
      int f, l, th;
      f = int'($urandom_range(255));
      l = int'($urandom_range(255));
      if (r % 3 != 0 && f > l) begin int t; t = f; f = l; l = t; end
      th = int'($urandom_range(700)) - 350;
      fill(r % 2);
      if (r % 2 == 1) th = int'($urandom_range(6)) - 3;
      run(1'($urandom), 1'($urandom), f, l, th, "R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule